// File: doc/BRIEF.md
# Four-Channel DAC Serial Register Front End

This block is the digital side of a four-channel voltage DAC. A host sends 32-bit frames over a three-wire serial link made of an active-low frame select, a serial clock and a data line. The block decodes each frame into a command, a channel address and a 16-bit code. It keeps an input register and a DAC register for each channel, and drives the four DAC register values as parallel codes to the converters.

The serial clock, the select, the load strobe and the clear strobe are all sampled into the system clock domain by two-flop synchronizers. Edges are found in that domain, so the system clock must run at least four times faster than the serial clock. A load input sets how writes reach the outputs. When load is held low, a write reaches the output at the end of the frame. When load is held high, writes wait, and a falling edge on load moves all four channels to their outputs together. A falling edge on the clear input forces every register to a programmable clear code. A strap pin chooses zero or midscale as the reset value of all registers.

Top module: `dac_serial_front`

## Requirements
- R1: A frame starts when `selN` goes low. Bits are taken on the next 32 falling edges of `sclk`, MSB first. Frame bit layout from MSB: bits 31..28 are ignored, 27..24 are the command, 23..20 are the address, 19..4 are the 16-bit code, and 3..0 are ignored.
- R2: If `selN` rises before the 32nd falling edge, the partial frame is dropped, no register changes, and the next frame decodes normally.
- R3: Command 4'h1 (write input) with `loadN` low writes the code into the addressed input register and also into the addressed DAC register.
- R4: Command 4'h1 with `loadN` high writes only the addressed input register. `dacCode` does not change.
- R5: A falling edge on `loadN` copies all four input registers into their DAC registers at once.
- R6: Command 4'h2 writes the addressed input and DAC registers, whatever the level of `loadN`.
- R7: Command 4'h3 copies all input registers into the DAC registers.
- R8: Address 4'h0 to 4'h3 selects channel A to D, and address 4'hF selects all four channels. Addresses 4'h4 to 4'hE change nothing.
- R9: A falling edge on `clearN` loads the current clear code into every input register and every DAC register.
- R10: While `clearN` is low, falling edges on `loadN` have no effect. Writes to input registers still take place.
- R11: Command 4'h4 sets the clear code from code bits [1:0]: 2'b00 gives zero (16'h0000), 2'b01 gives midscale (16'h8000) and 2'b10 gives full scale (16'hFFFF). 2'b11 leaves the clear code unchanged. After reset the clear code is zero.
- R12: During reset every register takes 16'h8000 when `midscaleAtReset` is 1, and 16'h0000 when it is 0.
- R13: Command values other than 4'h1 to 4'h4 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selN | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock; data taken on falling edges |
| sdi | input | 1 | Serial data, MSB first |
| loadN | input | 1 | Load strobe: low level = immediate update, falling edge = update all |
| clearN | input | 1 | Clear strobe, falling-edge triggered, blocks load while low |
| midscaleAtReset | input | 1 | Strap: 1 = midscale reset value, 0 = zero |
| dacCode | output | 64 | Channel DAC codes, channel A at bits [15:0] up to channel D at bits [63:48] |

## Verification
Every output effect follows the system-clock edge that first samples the triggering serial-clock, load or clear edge. It takes two synchronizer stages, then the registered control strobe, then the datapath register. So `dacCode` settles on the fourth system clock after that sample. The bench lets at least eight system clocks pass after the last triggering edge of any stimulus before it reads `dacCode`. It reads on the falling clock edge, well clear of the update cycle. Where a stimulus must change nothing (aborted frames, ignored addresses and commands, load pulses while clear is low), the bench reads the outputs after the same wait.

// File: rtl/dac_serial_front_pkg.sv
package dac_serial_front_pkg;
  localparam int ChanCount = 4;
  localparam int CodeWidth = 16;
  localparam int FrameBits = 32;
  localparam int CmdWidth  = 4;
  localparam int AddrWidth = 4;
  localparam int TailBits  = 4;
  localparam int PayloadBits = CmdWidth + AddrWidth + CodeWidth;
  localparam int ShiftStop   = FrameBits - TailBits;

  typedef enum logic [CmdWidth-1:0] {
    CMD_WR_INPUT   = 4'h1,
    CMD_WR_UPDATE  = 4'h2,
    CMD_UPDATE_ALL = 4'h3,
    CMD_CLEAR_CODE = 4'h4
  } cmd_e;

  localparam logic [AddrWidth-1:0] ADDR_ALL = '1;

  typedef struct packed {
    logic                 writeInput;
    logic                 updateSel;
    logic                 updateAll;
    logic                 writeClear;
    logic                 clearLoad;
    logic [ChanCount-1:0] chanMask;
    logic [CodeWidth-1:0] data;
  } strobe_t;
endpackage

// File: rtl/dac_serial_front_ctrl.sv
module dac_serial_front_ctrl
  import dac_serial_front_pkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    selN,
  input  logic    sclk,
  input  logic    sdi,
  input  logic    loadN,
  input  logic    clearN,
  output strobe_t strobeQ
);
  localparam int NumIn   = 5;
  localparam int IdxSel  = 0;
  localparam int IdxSclk = 1;
  localparam int IdxSdi  = 2;
  localparam int IdxLoad = 3;
  localparam int IdxClr  = 4;
  localparam int CntW    = $clog2(FrameBits + 1);

  logic [NumIn-1:0] rawIn;
  logic [NumIn-1:0] syncLvl;
  logic [NumIn-1:0] prevLvl;
  logic [NumIn-1:0][SyncStages-1:0] chain;

  assign rawIn = {clearN, loadN, sdi, sclk, selN};

  // Two-or-more-flop synchronizers, one per asynchronous input
  for (genvar gi = 0; gi < NumIn; gi++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[gi] <= '1;
      else       chain[gi] <= {chain[gi][SyncStages-2:0], rawIn[gi]};
    end
    assign syncLvl[gi] = chain[gi][SyncStages-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= '1;
    else       prevLvl <= syncLvl;
  end

  logic sclkFall, loadFall, clearFall, selActive;
  assign sclkFall  = prevLvl[IdxSclk] & ~syncLvl[IdxSclk];
  assign loadFall  = prevLvl[IdxLoad] & ~syncLvl[IdxLoad];
  assign clearFall = prevLvl[IdxClr]  & ~syncLvl[IdxClr];
  assign selActive = ~syncLvl[IdxSel];

  // Bit counter and payload shifter; leading don't-care bits fall off the top,
  // trailing don't-care bits are never shifted in.
  logic [CntW-1:0]        bitCnt;
  logic [PayloadBits-1:0] payload;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      payload <= '0;
    end else if (!selActive) begin
      bitCnt <= '0;
    end else if (sclkFall && bitCnt != CntW'(FrameBits)) begin
      bitCnt <= bitCnt + 1'b1;
      if (bitCnt < CntW'(ShiftStop))
        payload <= {payload[PayloadBits-2:0], syncLvl[IdxSdi]};
    end
  end

  logic frameDone;
  assign frameDone = selActive & sclkFall & (bitCnt == CntW'(FrameBits - 1));

  logic [CmdWidth-1:0]  cmdField;
  logic [AddrWidth-1:0] addrField;
  logic [CodeWidth-1:0] dataField;
  assign dataField = payload[CodeWidth-1:0];
  assign addrField = payload[CodeWidth +: AddrWidth];
  assign cmdField  = payload[CodeWidth + AddrWidth +: CmdWidth];

  logic [ChanCount-1:0] maskNext;
  always_comb begin
    maskNext = '0;
    if (addrField == ADDR_ALL) begin
      maskNext = '1;
    end else begin
      for (int i = 0; i < ChanCount; i++)
        if (addrField == AddrWidth'(i)) maskNext[i] = 1'b1;
    end
  end

  strobe_t strobeNext;
  always_comb begin
    strobeNext            = '0;
    strobeNext.chanMask   = maskNext;
    strobeNext.data       = dataField;
    strobeNext.writeInput = frameDone &&
                            (cmdField == CMD_WR_INPUT || cmdField == CMD_WR_UPDATE);
    strobeNext.updateSel  = frameDone &&
                            (cmdField == CMD_WR_UPDATE ||
                             (cmdField == CMD_WR_INPUT && !syncLvl[IdxLoad]));
    strobeNext.updateAll  = (frameDone && cmdField == CMD_UPDATE_ALL) ||
                            (loadFall && syncLvl[IdxClr]);
    strobeNext.writeClear = frameDone && cmdField == CMD_CLEAR_CODE;
    strobeNext.clearLoad  = clearFall;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobeQ <= '0;
    else       strobeQ <= strobeNext;
  end
endmodule

// File: rtl/dac_serial_front_datapath.sv
module dac_serial_front_datapath
  import dac_serial_front_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           midscaleAtReset,
  input  strobe_t                        strobeQ,
  output logic [ChanCount*CodeWidth-1:0] dacCode
);
  localparam logic [CodeWidth-1:0] ZeroCode = '0;
  localparam logic [CodeWidth-1:0] MidCode  = {1'b1, {(CodeWidth-1){1'b0}}};
  localparam logic [CodeWidth-1:0] FullCode = '1;

  logic [1:0]           clearSel;
  logic [CodeWidth-1:0] clearValue;
  logic [CodeWidth-1:0] resetValue;

  assign resetValue = midscaleAtReset ? MidCode : ZeroCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      clearSel <= 2'b00;
    else if (strobeQ.writeClear && strobeQ.data[1:0] != 2'b11)
      clearSel <= strobeQ.data[1:0];
  end

  always_comb begin
    case (clearSel)
      2'b01:   clearValue = MidCode;
      2'b10:   clearValue = FullCode;
      default: clearValue = ZeroCode;
    endcase
  end

  for (genvar ch = 0; ch < ChanCount; ch++) begin : g_chan
    logic [CodeWidth-1:0] inputQ;
    logic [CodeWidth-1:0] dacQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inputQ <= resetValue;
        dacQ   <= resetValue;
      end else if (strobeQ.clearLoad) begin
        inputQ <= clearValue;
        dacQ   <= clearValue;
      end else begin
        if (strobeQ.writeInput && strobeQ.chanMask[ch])
          inputQ <= strobeQ.data;
        if (strobeQ.updateSel && strobeQ.chanMask[ch])
          dacQ <= strobeQ.data;
        else if (strobeQ.updateAll)
          dacQ <= inputQ;
      end
    end

    assign dacCode[ch*CodeWidth +: CodeWidth] = dacQ;
  end
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
  import dac_serial_front_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        selN,
  input  logic        sclk,
  input  logic        sdi,
  input  logic        loadN,
  input  logic        clearN,
  input  logic        midscaleAtReset,
  output logic [63:0] dacCode
);
  strobe_t strobeQ;

  dac_serial_front_ctrl #(.SyncStages(2)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .selN    (selN),
    .sclk    (sclk),
    .sdi     (sdi),
    .loadN   (loadN),
    .clearN  (clearN),
    .strobeQ (strobeQ)
  );

  dac_serial_front_datapath datapath_i (
    .clk             (clk),
    .rstN            (rstN),
    .midscaleAtReset (midscaleAtReset),
    .strobeQ         (strobeQ),
    .dacCode         (dacCode)
  );
endmodule

// File: rtl/dac_serial_front_chk.sv
module dac_serial_front_chk
  import dac_serial_front_pkg::*;
(
  input logic                           clk,
  input logic                           rstN,
  input logic                           updAny,
  input logic                           clrLoad,
  input logic                           selUpdate,
  input logic [ChanCount-1:0]           selMask,
  input logic [CodeWidth-1:0]           selData,
  input logic [ChanCount*CodeWidth-1:0] dacCode
);
  localparam logic [CodeWidth-1:0] MidCode = {1'b1, {(CodeWidth-1){1'b0}}};

  // R4: outputs move only in the cycle after an update or clear strobe
  a_r4_dac_quiet_without_update: assert property (@(posedge clk) disable iff (!rstN)
    !updAny |=> $stable(dacCode));

  // R11: a clear always lands on one of the three legal codes
  a_r11_clear_code_legal: assert property (@(posedge clk) disable iff (!rstN)
    clrLoad |=> (dacCode[CodeWidth-1:0] == '0 || dacCode[CodeWidth-1:0] == MidCode ||
                 dacCode[CodeWidth-1:0] == '1));

  for (genvar ch = 1; ch < ChanCount; ch++) begin : g_uniform
    // R9: every channel takes the same clear value
    a_r9_clear_uniform: assert property (@(posedge clk) disable iff (!rstN)
      clrLoad |=> dacCode[ch*CodeWidth +: CodeWidth] == dacCode[CodeWidth-1:0]);
  end

  for (genvar ch = 0; ch < ChanCount; ch++) begin : g_select
    // R6: addressed immediate update carries the frame code to the output
    a_r6_selected_update: assert property (@(posedge clk) disable iff (!rstN)
      selUpdate && selMask[ch] && !clrLoad |=>
        dacCode[ch*CodeWidth +: CodeWidth] == $past(selData));
  end
endmodule

bind dac_serial_front dac_serial_front_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .updAny    (strobeQ.updateSel | strobeQ.updateAll | strobeQ.clearLoad),
  .clrLoad   (strobeQ.clearLoad),
  .selUpdate (strobeQ.updateSel),
  .selMask   (strobeQ.chanMask),
  .selData   (strobeQ.data),
  .dacCode   (dacCode)
);

// File: tb/dac_serial_front_tb_top.sv
module dac_serial_front_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        selN = 1'b1;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic        loadN = 1'b1;
  logic        clearN = 1'b1;
  logic        midscaleAtReset = 1'b1;
  logic [63:0] dacCode;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dac_serial_front dut_i (
    .clk(clk), .rstN(rstN), .selN(selN), .sclk(sclk), .sdi(sdi),
    .loadN(loadN), .clearN(clearN), .midscaleAtReset(midscaleAtReset),
    .dacCode(dacCode)
  );

  // {frame word, load held high, load pulse after, expected {D,C,B,A}}
  localparam int NumVec = 9;
  localparam logic [97:0] VECS [NumVec] = '{
    {32'h01011110, 1'b0, 1'b0, 64'h8000_8000_8000_1111}, // R3 write A, load low
    {32'h01122220, 1'b1, 1'b0, 64'h8000_8000_8000_1111}, // R4 write B, load high
    {32'h01233330, 1'b1, 1'b1, 64'h8000_3333_2222_1111}, // R5 load edge moves all
    {32'h02344440, 1'b1, 1'b0, 64'h4444_3333_2222_1111}, // R6 write+update D
    {32'h01F55550, 1'b1, 1'b0, 64'h4444_3333_2222_1111}, // R8 all inputs, held
    {32'h03000000, 1'b1, 1'b0, 64'h5555_5555_5555_5555}, // R7 update all command
    {32'h01699990, 1'b0, 1'b0, 64'h5555_5555_5555_5555}, // R8 address 6 ignored
    {32'h07077770, 1'b0, 1'b0, 64'h5555_5555_5555_5555}, // R13 unknown command
    {32'h02FABCD0, 1'b1, 1'b0, 64'hABCD_ABCD_ABCD_ABCD}  // R8 R6 broadcast write
  };
  localparam logic [23:0] VTAG [NumVec] = '{
    "R3 ", "R4 ", "R5 ", "R6 ", "R8 ", "R7 ", "R8 ", "R13", "R8 "
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBits(input logic [31:0] word, input int nbits);
    selN = 1'b0;
    tick(4);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b1;
      sdi  = word[31-i];
      tick(4);
      sclk = 1'b0;
      tick(4);
    end
    tick(4);
    selN = 1'b1;
    tick(8);
  endtask

  task automatic pulseLoad();
    loadN = 1'b0;
    tick(8);
    loadN = 1'b1;
    tick(8);
  endtask

  task automatic check(input string tag, input logic [63:0] expv);
    checks++;
    if (dacCode !== expv) begin
      errors++;
      $display("FAIL %s: dacCode=%h expected=%h", tag, dacCode, expv);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(5);
    rstN = 1'b1;
    tick(8);
    check("R12 midscale reset", 64'h8000_8000_8000_8000);

    for (int v = 0; v < NumVec; v++) begin
      loadN = VECS[v][65];
      tick(8);
      sendBits(VECS[v][97:66], 32);
      if (VECS[v][64]) pulseLoad();
      check($sformatf("%s vector %0d", VTAG[v], v), VECS[v][63:0]);
    end

    // R2: abort mid-frame, then R1: next full frame decodes
    loadN = 1'b1;
    tick(8);
    sendBits(32'h02012340, 20);
    check("R2 aborted frame", 64'hABCD_ABCD_ABCD_ABCD);
    sendBits(32'h02012340, 32);
    check("R1 frame after abort", 64'hABCD_ABCD_ABCD_1234);

    // R9: clear with the reset clear code (zero)
    clearN = 1'b0;
    tick(8);
    check("R9 clear to zero", 64'h0);
    clearN = 1'b1;
    tick(8);

    // R11: full-scale clear code
    sendBits(32'h04000020, 32);
    clearN = 1'b0;
    tick(8);
    check("R11 full-scale clear", 64'hFFFF_FFFF_FFFF_FFFF);
    clearN = 1'b1;
    tick(8);

    // R11: midscale clear code
    sendBits(32'h04000010, 32);
    sendBits(32'h02F13570, 32);
    clearN = 1'b0;
    tick(8);
    check("R11 midscale clear", 64'h8000_8000_8000_8000);
    clearN = 1'b1;
    tick(8);

    // R11: code 2'b11 keeps midscale
    sendBits(32'h04000030, 32);
    sendBits(32'h02F22220, 32);
    clearN = 1'b0;
    tick(8);
    check("R11 reserved code keeps", 64'h8000_8000_8000_8000);

    // R10: load edge ignored while clear is low
    sendBits(32'h01024680, 32);
    pulseLoad();
    check("R10 load blocked by clear", 64'h8000_8000_8000_8000);
    clearN = 1'b1;
    tick(8);
    pulseLoad();
    check("R10 R5 load after clear release", 64'h8000_8000_8000_2468);

    // R12: zero reset strap; R11: clear code back to zero
    rstN = 1'b0;
    midscaleAtReset = 1'b0;
    tick(5);
    rstN = 1'b1;
    tick(8);
    check("R12 zero reset", 64'h0);
    sendBits(32'h02FFFFF0, 32);
    check("R6 broadcast full", 64'hFFFF_FFFF_FFFF_FFFF);
    clearN = 1'b0;
    tick(8);
    check("R11 clear code zero after reset", 64'h0);
    clearN = 1'b1;
    tick(8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule